// File: doc/BRIEF.md
# Upstream Burst Assembler

This block times and builds one upstream burst per synchronization pulse. When the pulse arrives it captures the start and end word times of two allocation windows, one for the management container and one for the data container. From those times it works out where the burst has to begin. It then emits one 64-bit word per clock cycle in this order: a run of preamble words, a run of delimiter words, one embedded-operations word, a six-word management message, the management window and the data window.

Each window is filled from its own frame FIFO. The FIFOs are first-word-fall-through: the head word is visible while the FIFO is not empty, and a one-cycle pop removes it. A frame leaves its FIFO only if the whole frame fits before the end of its window. Every word in the burst that carries no other content is sent as a fixed idle pattern. The transmitter enable covers exactly the words of the burst.

Top module: `upstream_burst_asm`

## Requirements
- R1: Word time 0 is the word registered at the first clock edge after the edge that samples `syncPulse` high. Each later cycle is the next word time. The allocation valid, start and end inputs are captured at that pulse edge.
- R2: Let `oh = preLen + delimLen + 7`. The burst starts at word time `first - oh`, where `first` is the management start if that allocation is valid and the data start otherwise. The burst then carries `preLen` copies of `preambleWord`, `delimLen` copies of `delimWord` and one `eoamWord`.
- R3: The six words after the embedded-operations word are popped from the message FIFO if that FIFO is non-empty at the first of them. If it is empty there, the six words are all zero and nothing is popped.
- R4: Word times `mgmtStart` up to `mgmtEnd-1` carry frames taken from the management FIFO. A frame's length in words, counting its head word, is bits [15:0] of its head word.
- R5: Word times `dataStart` up to `dataEnd-1` carry frames taken from the data FIFO, with the same length field.
- R6: A frame is started only when its length is non-zero and no larger than the window end minus the current word time. Otherwise the word is `IDLE_WORD` (default 64'hA5C30F965A3CF069) and the frame stays in its FIFO.
- R7: A burst word that falls outside the overhead and outside both windows is `IDLE_WORD`. So is a window word while the FIFO of that window is empty.
- R8: `txEn` is high from the first preamble word through word time `last-1`, where `last` is the data end if the data allocation is valid and the management end otherwise. `txData` is zero whenever `txEn` is low.
- R9: An allocation that is not valid has its window skipped. If neither allocation is valid, no burst is sent.
- R10: If `first` is smaller than `oh`, no burst is sent and no FIFO is popped.
- R11: No FIFO is popped while it is empty. The two container FIFOs are never popped in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| syncPulse | input | 1 | Burst timing reference pulse |
| mgmtValid | input | 1 | Management allocation present |
| mgmtStart | input | TW | Management window first word time |
| mgmtEnd | input | TW | Management window end (exclusive) |
| dataValid | input | 1 | Data allocation present |
| dataStart | input | TW | Data window first word time |
| dataEnd | input | TW | Data window end (exclusive) |
| preLen | input | LW | Preamble length in words |
| delimLen | input | LW | Delimiter length in words |
| preambleWord | input | W | Preamble pattern |
| delimWord | input | W | Delimiter pattern |
| eoamWord | input | W | Embedded-operations word |
| msgEmpty | input | 1 | Message FIFO empty |
| msgData | input | W | Message FIFO head word |
| msgPop | output | 1 | Message FIFO pop |
| mgmtEmpty | input | 1 | Management FIFO empty |
| mgmtData | input | W | Management FIFO head word |
| mgmtPop | output | 1 | Management FIFO pop |
| dataEmpty | input | 1 | Data FIFO empty |
| dataData | input | W | Data FIFO head word |
| dataPop | output | 1 | Data FIFO pop |
| txEn | output | 1 | Transmitter enable |
| txData | output | W | Burst word |

## Verification
The bench builds one burst in which a management frame does not fit the words left in its window. A design that checked only for an empty FIFO would start that frame and run it past the window end, and the frame would not be left in the FIFO. The bench also runs bursts with the data FIFO empty, with only the data allocation valid, with an empty message FIFO, with neither allocation valid and with too little room for the overhead. A wrong overhead offset would move the whole burst by some words. A design that did not skip the missing window would emit stale frames, and a missing no-burst check would raise `txEn` early or underflow the start time. The idle gap between the two windows catches a design that lowers `txEn` between allocations.

// File: rtl/ubst_pkg.sv
package ubst_pkg;
  typedef enum logic [3:0] {
    SEL_OFF, SEL_PRE, SEL_DELIM, SEL_EOAM, SEL_MSG,
    SEL_ZERO, SEL_MGMT, SEL_DATA, SEL_IDLE
  } wordSelT;

  typedef struct packed {
    logic    en;
    wordSelT sel;
  } strobeT;

  localparam int MSG_WORDS = 6;
  localparam int LEN_BITS  = 16;
endpackage

// File: rtl/ubst_ctrl.sv
module ubst_ctrl
  import ubst_pkg::*;
#(
  parameter int TW = 16,
  parameter int LW = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                syncPulse,
  input  logic                mgmtValid,
  input  logic [TW-1:0]       mgmtStart,
  input  logic [TW-1:0]       mgmtEnd,
  input  logic                dataValid,
  input  logic [TW-1:0]       dataStart,
  input  logic [TW-1:0]       dataEnd,
  input  logic [LW-1:0]       preLen,
  input  logic [LW-1:0]       delimLen,
  input  logic                msgEmpty,
  input  logic [1:0]          fifoEmpty,
  input  logic [LEN_BITS-1:0] fifoLen [2],
  output logic                msgPop,
  output logic [1:0]          fifoPop,
  output strobeT              strobe
);
  localparam int OW = ((TW > LEN_BITS) ? TW : LEN_BITS) + 2;
  localparam logic [TW-1:0] T_MAX = '1;

  logic [TW-1:0] timeCnt;
  logic          armed, msgTaking;
  logic          winVal [2];
  logic [TW-1:0] winStart [2];
  logic [TW-1:0] winEnd [2];
  logic [OW-1:0] fraRem [2];

  logic [OW-1:0] tW, firstW, lastW, ohW, s0W, oW, preW, pdW;
  logic          burstOk, inBurst, inOverhead, msgFirst, msgTake;
  logic [1:0]    inWin, canSend;

  always_comb begin
    firstW   = winVal[0] ? OW'(winStart[0]) : OW'(winStart[1]);
    lastW    = winVal[1] ? OW'(winEnd[1])   : OW'(winEnd[0]);
    preW     = OW'(preLen);
    pdW      = OW'(preLen) + OW'(delimLen);
    ohW      = pdW + OW'(MSG_WORDS + 1);
    burstOk  = armed && (winVal[0] || winVal[1]) && (firstW >= ohW);
    s0W      = firstW - ohW;
    tW       = OW'(timeCnt);
    inBurst  = burstOk && (tW >= s0W) && (tW < lastW);
    oW       = tW - s0W;
    inOverhead = oW < ohW;
    msgFirst = (oW == pdW + OW'(1));
    msgTake  = msgFirst ? !msgEmpty : msgTaking;
  end

  for (genvar c = 0; c < 2; c++) begin : g_win
    always_comb begin
      inWin[c]   = inBurst && !inOverhead && winVal[c] &&
                   (tW >= OW'(winStart[c])) && (tW < OW'(winEnd[c]));
      canSend[c] = (fraRem[c] != '0) ||
                   (!fifoEmpty[c] && (fifoLen[c] != '0) &&
                    (OW'(fifoLen[c]) <= OW'(winEnd[c]) - tW));
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        fraRem[c] <= '0;
      end else if (syncPulse) begin
        fraRem[c] <= '0;
      end else if (inWin[c] && canSend[c]) begin
        fraRem[c] <= (fraRem[c] != '0) ? fraRem[c] - OW'(1)
                                       : OW'(fifoLen[c]) - OW'(1);
      end
    end
  end

  always_comb begin
    strobe.en  = inBurst;
    strobe.sel = SEL_OFF;
    msgPop     = 1'b0;
    fifoPop    = '0;
    if (inBurst) begin
      if (oW < preW)               strobe.sel = SEL_PRE;
      else if (oW < pdW)           strobe.sel = SEL_DELIM;
      else if (oW == pdW)          strobe.sel = SEL_EOAM;
      else if (inOverhead) begin
        strobe.sel = msgTake ? SEL_MSG : SEL_ZERO;
        msgPop     = msgTake;
      end else if (inWin[0]) begin
        strobe.sel = canSend[0] ? SEL_MGMT : SEL_IDLE;
        fifoPop[0] = canSend[0];
      end else if (inWin[1]) begin
        strobe.sel = canSend[1] ? SEL_DATA : SEL_IDLE;
        fifoPop[1] = canSend[1];
      end else                     strobe.sel = SEL_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      timeCnt   <= '0;
      armed     <= 1'b0;
      msgTaking <= 1'b0;
      for (int c = 0; c < 2; c++) begin
        winVal[c]   <= 1'b0;
        winStart[c] <= '0;
        winEnd[c]   <= '0;
      end
    end else if (syncPulse) begin
      timeCnt     <= '0;
      armed       <= 1'b1;
      msgTaking   <= 1'b0;
      winVal[0]   <= mgmtValid;
      winStart[0] <= mgmtStart;
      winEnd[0]   <= mgmtEnd;
      winVal[1]   <= dataValid;
      winStart[1] <= dataStart;
      winEnd[1]   <= dataEnd;
    end else begin
      if (timeCnt != T_MAX) timeCnt <= timeCnt + 1'b1;
      if (inBurst && msgFirst) msgTaking <= !msgEmpty;
    end
  end
endmodule

// File: rtl/ubst_dp.sv
module ubst_dp
  import ubst_pkg::*;
#(
  parameter int W = 64,
  parameter logic [W-1:0] IDLE_WORD = 64'hA5C30F965A3CF069
) (
  input  logic         clk,
  input  logic         rst_n,
  input  strobeT       strobe,
  input  logic [W-1:0] preambleWord,
  input  logic [W-1:0] delimWord,
  input  logic [W-1:0] eoamWord,
  input  logic [W-1:0] msgData,
  input  logic [W-1:0] mgmtData,
  input  logic [W-1:0] dataData,
  output logic         txEn,
  output logic [W-1:0] txData
);
  logic [W-1:0] nextWord;

  always_comb begin
    unique case (strobe.sel)
      SEL_PRE:   nextWord = preambleWord;
      SEL_DELIM: nextWord = delimWord;
      SEL_EOAM:  nextWord = eoamWord;
      SEL_MSG:   nextWord = msgData;
      SEL_MGMT:  nextWord = mgmtData;
      SEL_DATA:  nextWord = dataData;
      SEL_IDLE:  nextWord = IDLE_WORD;
      default:   nextWord = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txEn   <= 1'b0;
      txData <= '0;
    end else begin
      txEn   <= strobe.en;
      txData <= strobe.en ? nextWord : '0;
    end
  end
endmodule

// File: rtl/upstream_burst_asm.sv
module upstream_burst_asm
  import ubst_pkg::*;
#(
  parameter int W  = 64,
  parameter int TW = 16,
  parameter int LW = 4,
  parameter logic [W-1:0] IDLE_WORD = 64'hA5C30F965A3CF069
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          syncPulse,
  input  logic          mgmtValid,
  input  logic [TW-1:0] mgmtStart,
  input  logic [TW-1:0] mgmtEnd,
  input  logic          dataValid,
  input  logic [TW-1:0] dataStart,
  input  logic [TW-1:0] dataEnd,
  input  logic [LW-1:0] preLen,
  input  logic [LW-1:0] delimLen,
  input  logic [W-1:0]  preambleWord,
  input  logic [W-1:0]  delimWord,
  input  logic [W-1:0]  eoamWord,
  input  logic          msgEmpty,
  input  logic [W-1:0]  msgData,
  output logic          msgPop,
  input  logic          mgmtEmpty,
  input  logic [W-1:0]  mgmtData,
  output logic          mgmtPop,
  input  logic          dataEmpty,
  input  logic [W-1:0]  dataData,
  output logic          dataPop,
  output logic          txEn,
  output logic [W-1:0]  txData
);
  strobeT              strobe;
  logic [1:0]          fifoPop;
  logic [LEN_BITS-1:0] fifoLen [2];

  assign fifoLen[0] = mgmtData[LEN_BITS-1:0];
  assign fifoLen[1] = dataData[LEN_BITS-1:0];
  assign mgmtPop    = fifoPop[0];
  assign dataPop    = fifoPop[1];

  ubst_ctrl #(.TW(TW), .LW(LW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .syncPulse(syncPulse),
    .mgmtValid(mgmtValid), .mgmtStart(mgmtStart), .mgmtEnd(mgmtEnd),
    .dataValid(dataValid), .dataStart(dataStart), .dataEnd(dataEnd),
    .preLen(preLen), .delimLen(delimLen), .msgEmpty(msgEmpty),
    .fifoEmpty({dataEmpty, mgmtEmpty}), .fifoLen(fifoLen),
    .msgPop(msgPop), .fifoPop(fifoPop), .strobe(strobe)
  );

  ubst_dp #(.W(W), .IDLE_WORD(IDLE_WORD)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe),
    .preambleWord(preambleWord), .delimWord(delimWord), .eoamWord(eoamWord),
    .msgData(msgData), .mgmtData(mgmtData), .dataData(dataData),
    .txEn(txEn), .txData(txData)
  );
endmodule

// File: rtl/upstream_burst_asm_chk.sv
module upstream_burst_asm_chk #(
  parameter int W = 64
) (
  input logic         clk,
  input logic         rst_n,
  input logic         msgEmpty,
  input logic         msgPop,
  input logic         mgmtEmpty,
  input logic         mgmtPop,
  input logic         dataEmpty,
  input logic         dataPop,
  input logic         txEn,
  input logic [W-1:0] txData
);
  assert_no_mgmt_underflow_R11: assert property (@(posedge clk) disable iff (!rst_n)
    mgmtPop |-> !mgmtEmpty);
  assert_no_data_underflow_R11: assert property (@(posedge clk) disable iff (!rst_n)
    dataPop |-> !dataEmpty);
  assert_no_msg_underflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    msgPop |-> !msgEmpty);
  assert_one_container_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({mgmtPop, dataPop}) <= 1);
  assert_pop_in_burst_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mgmtPop || dataPop || msgPop) |=> txEn);
  assert_quiet_line_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !txEn |-> (txData == '0));
endmodule

bind upstream_burst_asm upstream_burst_asm_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .msgEmpty(msgEmpty), .msgPop(msgPop),
  .mgmtEmpty(mgmtEmpty), .mgmtPop(mgmtPop), .dataEmpty(dataEmpty),
  .dataPop(dataPop), .txEn(txEn), .txData(txData)
);

// File: tb/upstream_burst_asm_bench.sv
module upstream_burst_asm_bench;
  localparam int W = 64, TW = 16, LW = 4, N = 64, D = 32;
  localparam logic [W-1:0] IDLE = 64'hA5C30F965A3CF069;

  logic clk = 0, rst_n = 0, syncPulse = 0;
  logic mgmtValid = 0, dataValid = 0;
  logic [TW-1:0] mgmtStart = 0, mgmtEnd = 0, dataStart = 0, dataEnd = 0;
  logic [LW-1:0] preLen = 3, delimLen = 2;
  logic [W-1:0] preambleWord = 64'h1111_2222_3333_4444;
  logic [W-1:0] delimWord = 64'hD0D0_E1E1_F2F2_0303;
  logic [W-1:0] eoamWord = 64'h0E0E_0A0A_0B0B_0C0C;
  logic msgPop, mgmtPop, dataPop, txEn;
  logic [W-1:0] txData;

  logic [W-1:0] mArr [D], dArr [D], sArr [D];
  int mCnt, dCnt, sCnt, mHead, dHead, sHead;
  int errors = 0, checks = 0;
  logic          capEn [N];
  logic [W-1:0]  capData [N];
  logic          expEn [N];
  logic [W-1:0]  expData [N];

  wire msgEmpty  = sHead >= sCnt;
  wire mgmtEmpty = mHead >= mCnt;
  wire dataEmpty = dHead >= dCnt;
  wire [W-1:0] msgData  = msgEmpty  ? '0 : sArr[sHead];
  wire [W-1:0] mgmtData = mgmtEmpty ? '0 : mArr[mHead];
  wire [W-1:0] dataData = dataEmpty ? '0 : dArr[dHead];

  always #10 clk = ~clk;

  always @(posedge clk) begin
    if (msgPop)  sHead <= sHead + 1;
    if (mgmtPop) mHead <= mHead + 1;
    if (dataPop) dHead <= dHead + 1;
  end

  upstream_burst_asm #(.W(W), .TW(TW), .LW(LW)) u_upstream_burst_asm (
    .clk(clk), .rst_n(rst_n), .syncPulse(syncPulse),
    .mgmtValid(mgmtValid), .mgmtStart(mgmtStart), .mgmtEnd(mgmtEnd),
    .dataValid(dataValid), .dataStart(dataStart), .dataEnd(dataEnd),
    .preLen(preLen), .delimLen(delimLen), .preambleWord(preambleWord),
    .delimWord(delimWord), .eoamWord(eoamWord),
    .msgEmpty(msgEmpty), .msgData(msgData), .msgPop(msgPop),
    .mgmtEmpty(mgmtEmpty), .mgmtData(mgmtData), .mgmtPop(mgmtPop),
    .dataEmpty(dataEmpty), .dataData(dataData), .dataPop(dataPop),
    .txEn(txEn), .txData(txData)
  );

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Frames: head word carries the length in bits [15:0] (R4/R5)
  task automatic pushFrame(input int which, input int len, input int tag);
    for (int i = 0; i < len; i++) begin
      logic [W-1:0] w;
      w = (i == 0) ? {8'hF0, 8'(tag), 32'h0, 16'(len)} : {8'hB0, 8'(tag), 16'(i), 32'hCAFE0000};
      if (which == 0) begin mArr[mCnt] = w; mCnt++; end
      else begin dArr[dCnt] = w; dCnt++; end
    end
  endtask

  task automatic clearFifos();
    @(negedge clk);
    mCnt = 0; dCnt = 0; sCnt = 0; mHead = 0; dHead = 0; sHead = 0;
  endtask

  task automatic pushMsg(input int tag);
    for (int i = 0; i < 6; i++) begin sArr[sCnt] = {8'h4D, 8'(tag), 48'(i)}; sCnt++; end
  endtask

  // Independent model of the burst from the requirements
  task automatic buildExpected();
    int mh = mHead, dh = dHead, sh = sHead;
    int first, last, oh, s0, o, rem [2];
    bit ok, taking;
    int ws [2], we [2];
    bit wv [2];
    wv[0] = mgmtValid; ws[0] = mgmtStart; we[0] = mgmtEnd;
    wv[1] = dataValid; ws[1] = dataStart; we[1] = dataEnd;
    first = wv[0] ? ws[0] : ws[1];
    last  = wv[1] ? we[1] : we[0];
    oh = preLen + delimLen + 7;
    ok = (wv[0] || wv[1]) && first >= oh;
    s0 = first - oh;
    rem[0] = 0; rem[1] = 0; taking = 0;
    for (int t = 0; t < N; t++) begin
      expEn[t] = 0; expData[t] = '0;
      if (ok && t >= s0 && t < last) begin
        o = t - s0;
        expEn[t] = 1;
        if (o < preLen) expData[t] = preambleWord;
        else if (o < preLen + delimLen) expData[t] = delimWord;
        else if (o == preLen + delimLen) expData[t] = eoamWord;
        else if (o < oh) begin
          if (o == preLen + delimLen + 1) taking = sh < sCnt;
          if (taking) begin expData[t] = sArr[sh]; sh++; end
        end else begin
          expData[t] = IDLE;
          for (int c = 0; c < 2; c++) begin
            if (wv[c] && t >= ws[c] && t < we[c]) begin
              int h, cnt, len;
              h = (c == 0) ? mh : dh; cnt = (c == 0) ? mCnt : dCnt;
              len = (h < cnt) ? int'((c == 0) ? mArr[h][15:0] : dArr[h][15:0]) : 0;
              if (rem[c] == 0 && h < cnt && len != 0 && len <= we[c] - t) rem[c] = len;
              if (rem[c] > 0) begin
                expData[t] = (c == 0) ? mArr[h] : dArr[h];
                rem[c]--;
                if (c == 0) mh++; else dh++;
              end
            end
          end
        end
      end
    end
  endtask

  task automatic runBurst(input string req);
    buildExpected();
    @(negedge clk); syncPulse = 1;
    @(negedge clk); syncPulse = 0;
    for (int n = 0; n < N; n++) begin
      @(negedge clk);
      capEn[n] = txEn; capData[n] = txData;
    end
    for (int n = 0; n < N; n++) begin
      check(req, {63'b0, capEn[n]}, {63'b0, expEn[n]});
      check(req, capData[n], expData[n]);
    end
  endtask

  task automatic testReset();
    check("R8 reset txEn", {63'b0, txEn}, 64'd0);
    check("R8 reset txData", txData, 64'd0);
  endtask

  task automatic testFullBurst();
    clearFifos();
    pushMsg(1);
    pushFrame(0, 3, 1); pushFrame(0, 4, 2);
    pushFrame(1, 5, 3); pushFrame(1, 2, 4);
    mgmtValid = 1; mgmtStart = 20; mgmtEnd = 30;
    dataValid = 1; dataStart = 32; dataEnd = 45;
    runBurst("R1/R2/R3/R4/R5/R7/R8");
    check("R4 mgmt consumed", 64'(mHead), 64'd7);
    check("R5 data consumed", 64'(dHead), 64'd7);
    check("R3 msg consumed", 64'(sHead), 64'd6);
    // spot checks at fixed positions: burst starts at 20-12=8
    check("R2 first preamble word", capData[8], preambleWord);
    check("R8 before burst", {63'b0, capEn[7]}, 64'd0);
    check("R8 last word", {63'b0, capEn[44]}, 64'd1);
    check("R8 after burst", {63'b0, capEn[45]}, 64'd0);
    check("R7 gap idle", capData[31], IDLE);
  endtask

  task automatic testNoFit();
    clearFifos();
    pushMsg(2);
    pushFrame(0, 4, 5); pushFrame(0, 4, 6); pushFrame(0, 4, 7);
    mgmtValid = 1; mgmtStart = 20; mgmtEnd = 30;
    dataValid = 1; dataStart = 30; dataEnd = 36;
    runBurst("R6/R7");
    check("R6 third frame left in FIFO", 64'(mHead), 64'd8);
    check("R6 pad word", capData[28], IDLE);
    check("R7 empty data FIFO idle", capData[33], IDLE);
  endtask

  task automatic testDataOnly();
    clearFifos();
    pushFrame(0, 2, 8);
    pushFrame(1, 3, 9);
    mgmtValid = 0; mgmtStart = 5; mgmtEnd = 9;
    dataValid = 1; dataStart = 25; dataEnd = 31;
    runBurst("R9/R3");
    check("R9 mgmt untouched", 64'(mHead), 64'd0);
    check("R3 zero message word", capData[25 - 6], 64'd0);
    check("R9 burst start", {63'b0, capEn[13]}, 64'd1);
  endtask

  task automatic testNoAlloc();
    clearFifos();
    pushFrame(0, 2, 10); pushMsg(3);
    mgmtValid = 0; dataValid = 0; mgmtStart = 20; mgmtEnd = 30;
    runBurst("R9");
    check("R9 nothing popped", 64'(mHead + sHead), 64'd0);
  endtask

  task automatic testTooEarly();
    clearFifos();
    pushFrame(0, 2, 11); pushMsg(4);
    mgmtValid = 1; mgmtStart = 11; mgmtEnd = 20;
    dataValid = 0;
    runBurst("R10");
    check("R10 nothing popped", 64'(mHead + sHead), 64'd0);
  endtask

  initial begin
    for (int c = 0; c < 100000; c++) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    mCnt = 0; dCnt = 0; sCnt = 0; mHead = 0; dHead = 0; sHead = 0;
    repeat (3) @(negedge clk);
    testReset();
    rst_n = 1;
    testFullBurst();
    testNoFit();
    testDataOnly();
    testNoAlloc();
    testTooEarly();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule